// File: doc/BRIEF.md
# Boot Strap Capture and Core Release Controller

This block samples a set of configuration straps from pins that are shared with an address bus. The straps pass through a synchronizer while reset is held. The synchronized value is captured at the first clock edge after reset is released. From the captured 4-bit boot code the block decides how the processor core leaves reset:

- It can release the core at once, pointed at the right entry address.
- It can hold the core until an external host has loaded memory and signalled completion with an interrupt bit.
- It can hold the core indefinitely and flag an error when the code is reserved or the strap combination is invalid.

The captured straps also drive an endian select and a host-port width select, and they are visible as a status word.

A host interrupt is recorded as a sticky event flag. While that flag is set, further host interrupts are dropped. Software must clear the flag before another host interrupt can be taken. Every new reset, whatever its source, discards the previous capture and runs the whole sequence again.

Top module: `bootcfg_top`

## Requirements
- R1: While `rstN` is low, `coreHold` is 1 and `hostEvent`, `bootError` and `statusWord` are all 0.
- R2: At the first rising clock edge with `rstN` high, `statusWord` takes the strap value, provided the straps were stable for at least 3 cycles before that edge. Later strap changes leave `statusWord` unchanged until the next reset.
- R3: The strap fields are: boot code = bits [8:5], endian select = bit 4 (1 = little), host-port width = bit 3 (1 = 32-bit, 0 = 16-bit), general straps = bits [2:0]. `littleEndian` and `hostWide` follow the captured bits 4 and 3.
- R4: Boot code 0000 (no boot) releases the core (`coreHold` = 0) at the capture edge, with `startAddr` = 0x0080_0000 and `bootSoftware` = 0.
- R5: Boot code 0100 (8-bit external ROM) releases the core at the capture edge, with `startAddr` = 0xB000_0000 and `bootSoftware` = 0.
- R6: Boot codes 0101 (I2C master) and 0110 (I2C slave) release the core at the capture edge, with `startAddr` = 0x0010_0000 and `bootSoftware` = 1.
- R7: Boot codes 0001 (host port, `bootSoftware` = 0) and 0111 (PCI, `bootSoftware` = 1) keep `coreHold` at 1 until `hostIrqSet` is seen high at a clock edge. The core is released at that edge, and `startAddr` is 0x0080_0000.
- R8: An accepted `hostIrqSet` sets `hostEvent`. While `hostEvent` is 1, `hostIrqSet` is ignored and is not queued. A high `evtClear` clears `hostEvent` at the next edge, after which a new `hostIrqSet` is accepted again.
- R9: Boot codes 0010, 0011 and 1000 to 1111 set `bootError` and hold the core indefinitely, even if `hostIrqSet` arrives. `startAddr` is then 0.
- R10: Boot code 0111 with general straps other than 000 is treated as an error, the same way as R9.
- R11: A new reset after a completed boot discards the previous state and captures the straps present at the new release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset, covering every reset source |
| strapPins | input | 9 | Shared address pins carrying the configuration straps |
| hostIrqSet | input | 1 | Host write of the interrupt bit (one per cycle high) |
| evtClear | input | 1 | Software clear of the host event flag |
| coreHold | output | 1 | 1 holds the core stalled |
| bootSoftware | output | 1 | 1 when the selected mode runs the on-chip loader |
| bootError | output | 1 | Invalid boot configuration |
| littleEndian | output | 1 | Captured endian select |
| hostWide | output | 1 | Captured host-port width select |
| startAddr | output | 32 | Entry address the core uses on release |
| statusWord | output | 9 | Captured strap value |
| hostEvent | output | 1 | Sticky host interrupt event (event 0) |

## Verification
The assertions assume the straps do not change in the last three cycles before reset is released. They also assume `rstN` is released away from the clock edge, so that the captured value is well defined. The bench sets the straps while reset is low, waits several cycles, and only then lifts `rstN`, on a falling edge. It changes straps after release only to show that the change is ignored. `hostIrqSet` and `evtClear` are driven as single-cycle pulses, also on falling edges.

// File: rtl/bootcfg_pkg.sv
package bootcfg_pkg;
  localparam int STRAP_W = 9;
  localparam int CODE_LSB = 5;
  localparam int ENDIAN_BIT = 4;
  localparam int WIDTH_BIT = 3;
  localparam int GP_W = 3;

  localparam logic [3:0] CODE_NONE = 4'b0000;
  localparam logic [3:0] CODE_HPORT = 4'b0001;
  localparam logic [3:0] CODE_EROM = 4'b0100;
  localparam logic [3:0] CODE_I2CM = 4'b0101;
  localparam logic [3:0] CODE_I2CS = 4'b0110;
  localparam logic [3:0] CODE_PCI = 4'b0111;

  typedef enum logic [1:0] {
    ST_LATCH = 2'd0,
    ST_HOSTWAIT = 2'd1,
    ST_RUN = 2'd2,
    ST_FAULT = 2'd3
  } bootState_t;

  typedef struct packed {
    logic capture;
    logic faulted;
  } ctrlStrobes_t;

  function automatic logic codeValid(input logic [3:0] c);
    return (c == CODE_NONE) || (c == CODE_HPORT) || (c == CODE_EROM) ||
           (c == CODE_I2CM) || (c == CODE_I2CS) || (c == CODE_PCI);
  endfunction

  function automatic logic codeIsHost(input logic [3:0] c);
    return (c == CODE_HPORT) || (c == CODE_PCI);
  endfunction

  function automatic logic codeIsSoftware(input logic [3:0] c);
    return (c == CODE_PCI) || (c == CODE_I2CM) || (c == CODE_I2CS);
  endfunction
endpackage

// File: rtl/bootcfg_datapath.sv
module bootcfg_datapath
  import bootcfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] INT_RAM_BASE = 32'h0080_0000,
  parameter logic [ADDR_W-1:0] LOADER_BASE = 32'h0010_0000,
  parameter logic [ADDR_W-1:0] EXT_ROM_BASE = 32'hB000_0000
) (
  input  logic clk,
  input  logic rstN,
  input  logic [STRAP_W-1:0] strapPins,
  input  logic hostIrqSet,
  input  logic evtClear,
  input  ctrlStrobes_t strobes,
  output logic pendHost,
  output logic pendFault,
  output logic irqAccept,
  output logic [STRAP_W-1:0] statusWord,
  output logic littleEndian,
  output logic hostWide,
  output logic bootSoftware,
  output logic [ADDR_W-1:0] startAddr,
  output logic hostEvent
);
  logic [STRAP_W-1:0] syncChain [SYNC_STAGES];
  logic [STRAP_W-1:0] syncOut;
  logic [3:0] syncCode;
  logic [3:0] heldCode;
  logic [STRAP_W-1:0] latched;
  logic eventQ;

  // Straps are sampled while reset is low, so the chain carries no reset.
  genvar gi;
  generate
    for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_sync
      if (gi == 0) begin : g_first
        always_ff @(posedge clk) syncChain[gi] <= strapPins;
      end else begin : g_next
        always_ff @(posedge clk) syncChain[gi] <= syncChain[gi-1];
      end
    end
  endgenerate

  assign syncOut = syncChain[SYNC_STAGES-1];
  assign syncCode = syncOut[CODE_LSB +: 4];

  always_comb begin
    pendFault = !codeValid(syncCode) ||
                ((syncCode == CODE_PCI) && (syncOut[GP_W-1:0] != '0));
    pendHost = codeIsHost(syncCode);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) latched <= '0;
    else if (strobes.capture) latched <= syncOut;
  end

  assign heldCode = latched[CODE_LSB +: 4];
  assign statusWord = latched;
  assign littleEndian = latched[ENDIAN_BIT];
  assign hostWide = latched[WIDTH_BIT];
  assign bootSoftware = codeIsSoftware(heldCode) && !strobes.faulted;

  always_comb begin
    if (strobes.faulted) startAddr = '0;
    else if (heldCode == CODE_EROM) startAddr = EXT_ROM_BASE;
    else if ((heldCode == CODE_I2CM) || (heldCode == CODE_I2CS)) startAddr = LOADER_BASE;
    else startAddr = INT_RAM_BASE;
  end

  // Sticky event 0: a pending event blocks new host interrupts.
  assign irqAccept = hostIrqSet && !eventQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) eventQ <= 1'b0;
    else if (eventQ) eventQ <= !evtClear;
    else eventQ <= hostIrqSet;
  end

  assign hostEvent = eventQ;
endmodule

// File: rtl/bootcfg_control.sv
module bootcfg_control
  import bootcfg_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic pendHost,
  input  logic pendFault,
  input  logic irqAccept,
  output ctrlStrobes_t strobes,
  output logic coreHold,
  output logic bootError
);
  bootState_t state, nextState;

  always_comb begin
    nextState = state;
    case (state)
      ST_LATCH: begin
        if (pendFault) nextState = ST_FAULT;
        else if (pendHost) nextState = ST_HOSTWAIT;
        else nextState = ST_RUN;
      end
      ST_HOSTWAIT: if (irqAccept) nextState = ST_RUN;
      ST_RUN: nextState = ST_RUN;
      ST_FAULT: nextState = ST_FAULT;
      default: nextState = ST_FAULT;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_LATCH;
    else state <= nextState;
  end

  always_comb begin
    strobes.capture = (state == ST_LATCH);
    strobes.faulted = (state == ST_FAULT);
  end

  assign coreHold = (state != ST_RUN);
  assign bootError = (state == ST_FAULT);
endmodule

// File: rtl/bootcfg_top.sv
module bootcfg_top
  import bootcfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] INT_RAM_BASE = 32'h0080_0000,
  parameter logic [ADDR_W-1:0] LOADER_BASE = 32'h0010_0000,
  parameter logic [ADDR_W-1:0] EXT_ROM_BASE = 32'hB000_0000
) (
  input  logic clk,
  input  logic rstN,
  input  logic [8:0] strapPins,
  input  logic hostIrqSet,
  input  logic evtClear,
  output logic coreHold,
  output logic bootSoftware,
  output logic bootError,
  output logic littleEndian,
  output logic hostWide,
  output logic [ADDR_W-1:0] startAddr,
  output logic [8:0] statusWord,
  output logic hostEvent
);
  ctrlStrobes_t strobes;
  logic pendHost;
  logic pendFault;
  logic irqAccept;

  bootcfg_datapath #(
    .SYNC_STAGES(SYNC_STAGES),
    .ADDR_W(ADDR_W),
    .INT_RAM_BASE(INT_RAM_BASE),
    .LOADER_BASE(LOADER_BASE),
    .EXT_ROM_BASE(EXT_ROM_BASE)
  ) uDatapath (
    .clk(clk),
    .rstN(rstN),
    .strapPins(strapPins),
    .hostIrqSet(hostIrqSet),
    .evtClear(evtClear),
    .strobes(strobes),
    .pendHost(pendHost),
    .pendFault(pendFault),
    .irqAccept(irqAccept),
    .statusWord(statusWord),
    .littleEndian(littleEndian),
    .hostWide(hostWide),
    .bootSoftware(bootSoftware),
    .startAddr(startAddr),
    .hostEvent(hostEvent)
  );

  bootcfg_control uControl (
    .clk(clk),
    .rstN(rstN),
    .pendHost(pendHost),
    .pendFault(pendFault),
    .irqAccept(irqAccept),
    .strobes(strobes),
    .coreHold(coreHold),
    .bootError(bootError)
  );
endmodule

// File: rtl/bootcfg_checker.sv
module bootcfg_checker (
  input logic clk,
  input logic rstN,
  input logic hostIrqSet,
  input logic evtClear,
  input logic coreHold,
  input logic bootError,
  input logic [8:0] statusWord,
  input logic hostEvent
);
  logic [1:0] edgesSinceRst;
  logic [3:0] heldCode;

  assign heldCode = statusWord[8:5];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) edgesSinceRst <= 2'd0;
    else if (edgesSinceRst != 2'd2) edgesSinceRst <= edgesSinceRst + 2'd1;
  end

  always @(posedge clk) begin
    if (!rstN) begin
      AST_HOLD_IN_RESET: assert (coreHold && !hostEvent && !bootError); // R1
    end
  end

  AST_STATUS_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (edgesSinceRst == 2'd2) |-> $stable(statusWord)); // R2

  AST_HOST_RELEASE_NEEDS_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(coreHold) && ((heldCode == 4'b0001) || (heldCode == 4'b0111)))
      |-> $past(hostIrqSet)); // R7

  AST_EVENT_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (hostEvent && !evtClear) |=> hostEvent); // R8

  AST_ERROR_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    bootError |-> coreHold); // R9
endmodule

bind bootcfg_top bootcfg_checker uChecker (
  .clk(clk),
  .rstN(rstN),
  .hostIrqSet(hostIrqSet),
  .evtClear(evtClear),
  .coreHold(coreHold),
  .bootError(bootError),
  .statusWord(statusWord),
  .hostEvent(hostEvent)
);

// File: tb/tb_bootcfg_top.sv
module tb_bootcfg_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [8:0] strapPins = '0;
  logic hostIrqSet = 1'b0;
  logic evtClear = 1'b0;
  logic coreHold, bootSoftware, bootError, littleEndian, hostWide, hostEvent;
  logic [31:0] startAddr;
  logic [8:0] statusWord;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  bootcfg_top dut (
    .clk(clk), .rstN(rstN), .strapPins(strapPins), .hostIrqSet(hostIrqSet),
    .evtClear(evtClear), .coreHold(coreHold), .bootSoftware(bootSoftware),
    .bootError(bootError), .littleEndian(littleEndian), .hostWide(hostWide),
    .startAddr(startAddr), .statusWord(statusWord), .hostEvent(hostEvent)
  );

  // {strap[8:0], hold, sw, err, addr[31:0]}
  localparam int NVEC = 10;
  localparam logic [43:0] VECS [NVEC] = '{
    {9'b0000_1_0_000, 1'b0, 1'b0, 1'b0, 32'h0080_0000},
    {9'b0100_0_1_101, 1'b0, 1'b0, 1'b0, 32'hB000_0000},
    {9'b0101_1_1_011, 1'b0, 1'b1, 1'b0, 32'h0010_0000},
    {9'b0110_0_0_000, 1'b0, 1'b1, 1'b0, 32'h0010_0000},
    {9'b0001_1_0_010, 1'b1, 1'b0, 1'b0, 32'h0080_0000},
    {9'b0111_0_0_000, 1'b1, 1'b1, 1'b0, 32'h0080_0000},
    {9'b0111_1_0_100, 1'b1, 1'b0, 1'b1, 32'h0000_0000},
    {9'b0010_1_1_111, 1'b1, 1'b0, 1'b1, 32'h0000_0000},
    {9'b1011_0_1_001, 1'b1, 1'b0, 1'b1, 32'h0000_0000},
    {9'b1111_1_0_000, 1'b1, 1'b0, 1'b1, 32'h0000_0000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bootWith(input logic [8:0] s);
    @(negedge clk);
    rstN = 1'b0;
    strapPins = s;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic pulse(input logic irq, input logic clr);
    hostIrqSet = irq;
    evtClear = clr;
    @(negedge clk);
    hostIrqSet = 1'b0;
    evtClear = 1'b0;
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    strapPins = 9'b0000_1_1_111;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 hold", {31'd0, coreHold}, 32'd1);
    check("R1 event", {31'd0, hostEvent}, 32'd0);
    check("R1 error", {31'd0, bootError}, 32'd0);
    check("R1 status", {23'd0, statusWord}, 32'd0);

    for (int i = 0; i < NVEC; i++) begin
      logic [8:0] s;
      logic eh, es, ee;
      logic [31:0] ea;
      {s, eh, es, ee, ea} = VECS[i];
      bootWith(s);
      check("R2 status", {23'd0, statusWord}, {23'd0, s});
      check("R3 endian", {31'd0, littleEndian}, {31'd0, s[4]});
      check("R3 width", {31'd0, hostWide}, {31'd0, s[3]});
      check(ee ? "R9 hold" : (eh ? "R7 hold" : "R4 R5 R6 hold"), {31'd0, coreHold}, {31'd0, eh});
      check(s == 9'b0111_1_0_100 ? "R10 error" : "R9 error", {31'd0, bootError}, {31'd0, ee});
      check("R6 software", {31'd0, bootSoftware}, {31'd0, es});
      check("R4 R5 R6 addr", startAddr, ea);
      if (eh) begin
        repeat (3) @(negedge clk);
        check("R7 still held", {31'd0, coreHold}, 32'd1);
        pulse(1'b1, 1'b0);
        check(ee ? "R9 no release" : "R7 released", {31'd0, coreHold}, {31'd0, ee});
        if (!ee) check("R7 addr", startAddr, 32'h0080_0000);
      end
    end

    // R2 straps changing after capture are ignored
    bootWith(9'b0000_0_0_001);
    strapPins = 9'b1111_1_1_110;
    repeat (4) @(negedge clk);
    check("R2 frozen", {23'd0, statusWord}, 32'h001);

    // R8 sticky event on a host-port boot
    bootWith(9'b0001_0_0_000);
    check("R8 idle", {31'd0, hostEvent}, 32'd0);
    pulse(1'b1, 1'b0);
    check("R8 set", {31'd0, hostEvent}, 32'd1);
    check("R8 release", {31'd0, coreHold}, 32'd0);
    pulse(1'b1, 1'b0);
    check("R8 held", {31'd0, hostEvent}, 32'd1);
    pulse(1'b0, 1'b1);
    check("R8 cleared, not queued", {31'd0, hostEvent}, 32'd0);
    @(negedge clk);
    check("R8 stays clear", {31'd0, hostEvent}, 32'd0);
    pulse(1'b1, 1'b0);
    check("R8 re-accepted", {31'd0, hostEvent}, 32'd1);

    // R11 a new reset restarts the sequence
    bootWith(9'b0110_1_0_010);
    check("R11 relatch", {23'd0, statusWord}, 32'h0D2);
    check("R11 event cleared", {31'd0, hostEvent}, 32'd0);
    check("R11 released", {31'd0, coreHold}, 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule